// File: doc/BRIEF.md
# Four-Level Frame Sync Detector

This block sits on the receive side of a four-level FSK data link, after the slicer. It takes one 2-bit symbol per strobe and keeps the most recent `SYNC_LEN` symbols in a sliding window. After each accepted symbol it compares the window with a fixed sync pattern and reports how many symbol positions differ. When that count is at or below a run-time threshold, it raises a one-cycle `hit` pulse to mark the start of a frame.

After a hit, the block stops searching. It takes the next symbol as the channel status symbol and latches it. It then lets the station-identity field of `SID_LEN` symbols go by, and after that it searches again. While `rx_en` is low, as it is during transmit, symbol strobes are ignored completely. The sync pattern is a parameter, so either of the link's sync sequences can be searched for.

Top module: `fsync4_detect`

## Requirements
- R1: After a synchronous reset, `hit` is 0, `mismatches` is 0 and `chan_stat` is 2'b00. The symbol history is empty.
- R2: Symbols use the codes +3=2'b11, +1=2'b10, -1=2'b00 and -3=2'b01. In `SYNC_PAT`, bits [2*SYNC_LEN-1 -: 2] hold the first-sent symbol and bits [1:0] hold the most recent one.
- R3: One clock after each accepted strobe, `mismatches` equals the number of positions, among the last `SYNC_LEN` symbols, whose 2-bit code differs from the pattern.
- R4: `hit` is a single-cycle pulse. It appears one clock after an accepted strobe when searching, at least `SYNC_LEN` symbols have been accepted since reset, and the count is at most `thresh`.
- R5: A strobe with `rx_en` low has no effect. The history, count, status and tracking position all stay unchanged, and no `hit` follows.
- R6: The first accepted symbol after a hit is stored in `chan_stat`, visible one clock after its strobe. Its meaning is busy for 2'b11, idle for 2'b01 and unknown otherwise.
- R7: Searching is suppressed for the status symbol and the `SID_LEN` symbols after it. The symbol after those can produce a new hit.
- R8: A `thresh` of 0 accepts only an exact match. A `thresh` of `SYNC_LEN` accepts any full window.
- R9: `hit` is never raised unless the preceding clock held an accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | Receive mode; strobes are ignored while low |
| sym_stb | input | 1 | One-cycle strobe marking a valid symbol |
| sym | input | 2 | Sliced four-level symbol code |
| thresh | input | CW | Largest mismatch count that still counts as a hit |
| hit | output | 1 | Frame-start pulse |
| mismatches | output | CW | Mismatch count of the current window |
| chan_stat | output | 2 | Latched channel status symbol |

## Verification
The bench builds the block with `SYNC_LEN`=4, `SID_LEN`=3 and pattern 8'hD8. All 256 possible windows can then be swept exhaustively as one continuous stream, and hits, status captures and re-arming happen many times within a short run. Thresholds of 0, 1, 2 and 4 cover the exact-match and accept-everything extremes. Resets in mid-stream show that a hit waits for a full window after reset, and bursts of strobes with receive mode off show that history and tracking are left untouched.

// File: rtl/fsync4_detect.sv
module fsync4_detect #(
  parameter int SYNC_LEN = 24,
  parameter int SID_LEN  = 22,
  parameter logic [2*SYNC_LEN-1:0] SYNC_PAT = 48'hF5F5F5FF555F,
  localparam int CW = $clog2(SYNC_LEN + 1),
  localparam int SW = $clog2(SID_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_en,
  input  logic          sym_stb,
  input  logic [1:0]    sym,
  input  logic [CW-1:0] thresh,
  output logic          hit,
  output logic [CW-1:0] mismatches,
  output logic [1:0]    chan_stat
);
  typedef enum logic [1:0] {SEARCH, STAT, SID} st_t;

  localparam logic [CW-1:0] FULL = CW'(SYNC_LEN);
  localparam logic [SW-1:0] SID_LAST = SW'(SID_LEN - 1);

  st_t                  st;
  logic [2*SYNC_LEN-1:0] hist;
  logic [CW-1:0]        fill;
  logic [SW-1:0]        sid_cnt;
  logic [CW-1:0]        cnt_n;

  wire                  acc = rx_en & sym_stb;
  wire [2*SYNC_LEN-1:0] nh  = {hist[2*SYNC_LEN-3:0], sym};
  wire                  filled_n = (32'(fill) + 32'd1) >= 32'(SYNC_LEN);

  always_comb begin
    cnt_n = '0;
    for (int i = 0; i < SYNC_LEN; i++)
      cnt_n = cnt_n + {{(CW-1){1'b0}}, (nh[2*i +: 2] != SYNC_PAT[2*i +: 2])};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SEARCH;
      hist       <= '0;
      fill       <= '0;
      sid_cnt    <= '0;
      hit        <= 1'b0;
      mismatches <= '0;
      chan_stat  <= 2'b00;
    end else begin
      hit <= 1'b0;
      if (acc) begin
        hist       <= nh;
        mismatches <= cnt_n;
        if (fill != FULL) fill <= fill + 1'b1;
        case (st)
          SEARCH: if (filled_n && cnt_n <= thresh) begin
            hit <= 1'b1;
            st  <= STAT;
          end
          STAT: begin
            chan_stat <= sym;
            sid_cnt   <= '0;
            st        <= SID;
          end
          default: begin
            if (sid_cnt == SID_LAST) st <= SEARCH;
            else sid_cnt <= sid_cnt + 1'b1;
          end
        endcase
      end
    end
  end
endmodule

module fsync4_detect_chk #(
  parameter int SYNC_LEN = 24,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          rx_en,
  input logic          sym_stb,
  input logic [CW-1:0] thresh,
  input logic          hit,
  input logic [CW-1:0] mismatches,
  input logic [1:0]    chan_stat
);
  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(mismatches) <= 32'(SYNC_LEN));
  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);
  // R4
  hit_thresh_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> mismatches <= $past(thresh));
  // R9
  hit_after_stb_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(sym_stb && rx_en));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sym_stb && rx_en)) |->
      ($stable(mismatches) && $stable(chan_stat) && !hit));
endmodule

bind fsync4_detect fsync4_detect_chk #(.SYNC_LEN(SYNC_LEN), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .rx_en(rx_en), .sym_stb(sym_stb), .thresh(thresh),
  .hit(hit), .mismatches(mismatches), .chan_stat(chan_stat)
);

// File: tb/sim_fsync4_detect.sv
module sim_fsync4_detect;
  localparam int N  = 4;
  localparam int S  = 3;
  localparam int CW = $clog2(N + 1);
  localparam logic [2*N-1:0] PAT = 8'hD8;

  logic clk = 1'b0, rst = 1'b1, rx_en = 1'b0, sym_stb = 1'b0;
  logic [1:0] sym = 2'b00;
  logic [CW-1:0] thresh = '0;
  logic hit;
  logic [CW-1:0] mismatches;
  logic [1:0] chan_stat;

  int total = 0, bad = 0;
  logic [2*N-1:0] m_hist;
  int m_fill, m_phase, m_sid, m_mm, m_stat;
  logic [31:0] lcg = 32'h1234_5678;

  always #10 clk = ~clk;

  fsync4_detect #(.SYNC_LEN(N), .SID_LEN(S), .SYNC_PAT(PAT)) u0 (
    .clk(clk), .rst(rst), .rx_en(rx_en), .sym_stb(sym_stb), .sym(sym),
    .thresh(thresh), .hit(hit), .mismatches(mismatches), .chan_stat(chan_stat)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int diff_count(input logic [2*N-1:0] w);
    int c = 0;
    for (int i = 0; i < N; i++) if (w[2*i +: 2] != PAT[2*i +: 2]) c++;
    return c;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; sym_stb = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_hist = '0; m_fill = 0; m_phase = 0; m_sid = 0; m_mm = 0; m_stat = 0;
    // R1
    chk(hit == 1'b0, "R1 hit", int'(hit), 0);
    chk(mismatches == '0, "R1 mismatches", int'(mismatches), 0);
    chk(chan_stat == 2'b00, "R1 chan_stat", int'(chan_stat), 0);
  endtask

  // R2 R3 R4 R6 R7: bench model built from the requirement text
  task automatic send(input logic [1:0] s, input bit en, input string htag);
    int e_hit = 0;
    @(negedge clk);
    sym = s; rx_en = en; sym_stb = 1'b1;
    @(negedge clk);
    sym_stb = 1'b0;
    if (en) begin
      m_hist = {m_hist[2*N-3:0], s};
      if (m_fill < N) m_fill++;
      m_mm = diff_count(m_hist);
      case (m_phase)
        0: if (m_fill >= N && m_mm <= int'(thresh)) begin e_hit = 1; m_phase = 1; end
        1: begin m_stat = int'(s); m_phase = 2; m_sid = 0; end
        default: begin m_sid++; if (m_sid == S) m_phase = 0; end
      endcase
      chk(int'(mismatches) == m_mm, "R3 mismatches", int'(mismatches), m_mm);
      chk(int'(hit) == e_hit, htag, int'(hit), e_hit);
      chk(int'(chan_stat) == m_stat, "R6 chan_stat", int'(chan_stat), m_stat);
    end else begin
      chk(int'(mismatches) == m_mm, "R5 mismatches held", int'(mismatches), m_mm);
      chk(hit == 1'b0, "R5 no hit", int'(hit), 0);
      chk(int'(chan_stat) == m_stat, "R5 chan_stat held", int'(chan_stat), m_stat);
    end
    @(negedge clk);
    chk(hit == 1'b0, "R4 pulse width", int'(hit), 0);
  endtask

  function automatic logic [1:0] rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg[17:16];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    thresh = CW'(1);
    // R3 R4 R7: exhaustive sweep of all 4-symbol windows
    for (int v = 0; v < 256; v++)
      for (int k = 3; k >= 0; k--) send(v[2*k +: 2], 1'b1, "R4 hit");
    // R5: strobes with receive off do nothing
    for (int j = 0; j < 12; j++) send(rnd(), 1'b0, "R5");
    for (int j = 0; j < 200; j++) send(rnd(), 1'b1, "R4 hit");

    // R8: exact match only
    do_reset();
    thresh = '0;
    for (int j = 0; j < 300; j++) send(rnd(), 1'b1, "R8 exact");
    for (int k = 3; k >= 0; k--) send(PAT[2*k +: 2], 1'b1, "R8 exact");
    send(2'b11, 1'b1, "R6 busy");
    chk(chan_stat == 2'b11, "R6 busy", int'(chan_stat), 3);
    for (int j = 0; j < S; j++) send(PAT[7:6], 1'b1, "R7 suppress");
    for (int k = 3; k >= 0; k--) send(PAT[2*k +: 2], 1'b1, "R7 rearm");
    send(2'b01, 1'b1, "R6 idle");
    chk(chan_stat == 2'b01, "R6 idle", int'(chan_stat), 1);

    // R8: accept any full window; R4 waits for a full window after reset
    do_reset();
    thresh = CW'(N);
    for (int j = 0; j < 60; j++) send(rnd(), 1'b1, "R8 any");

    do_reset();
    thresh = CW'(2);
    for (int j = 0; j < 400; j++) send(rnd(), (j % 9) != 4, "R4 hit");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule